// File: doc/BRIEF.md
# Receive Loss-of-Signal Detector

This block sits behind clock recovery on a line receiver. It watches each recovered bit, marked by a one-cycle enable, and keeps a loss-of-signal flag. The flag rises after a long unbroken run of received zeros. It also rises while either of two outside conditions is reported: the receive gain sits at its ceiling, or the analog level detector says the input is too weak. The flag falls only when the recent bit history shows enough pulse density and contains no excessive zero run. While the flag is up, the received data passed downstream is forced low.

Data arrives either as two bipolar rails or as one unipolar data line. A parameter selects the variant. A second parameter decides whether a software-visible status bit copies the flag or stays at zero. The window length, the density threshold, the zero-run limit for exit and the zero count that declares loss are all parameters.

Top module: `los_detector`

## Requirements
- R1: While `rst_n` is low, and from the first clock edge at which it is sampled low, `los` is 1 and both data outputs are 0. After release, `los` stays 1 until the exit rule clears it.
- R2: When a bit period carries the 175th consecutive zero, `los` is 1 from the clock edge that samples that bit. A mark in any earlier bit period restarts the count. A bit is a mark when either rail is 1 (bipolar) or when `rx_pos` is 1 (unipolar).
- R3: A clock edge that samples `gain_max` or `low_level` high sets `los` to 1. That edge also restarts the count of bit periods observed toward exit.
- R4: Only cycles with `bit_en` high count as bit periods. In other cycles, the values on `rx_pos` and `rx_neg` change neither `los` nor the data outputs.
- R5: With `los` at 1, the bit period that completes 175 bit periods since the last declaration clears `los`, provided the last 175 bits hold at least 22 marks and R6 does not block. A declaration is reset, R2 or R3. If these conditions are not met, `los` stays 1.
- R6: Exit is blocked while the last 175 bits contain a run of 101 or more consecutive zeros.
- R7: When `los` is 0, `out_pos` and `out_neg` carry the rail values sampled in the most recent bit period. When `los` is 1, both are 0.
- R8: In the unipolar variant (`BIPOLAR`=0), only `rx_pos` carries data, `rx_neg` is ignored, and `out_neg` is always 0.
- R9: With `HOST_MODE`=1, `los_status` equals `los`. With `HOST_MODE`=0, `los_status` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bit_en | input | 1 | High for one cycle per recovered bit period |
| rx_pos | input | 1 | Positive rail, or unipolar data |
| rx_neg | input | 1 | Negative rail (unused in unipolar variant) |
| gain_max | input | 1 | Receive gain is at its maximum |
| low_level | input | 1 | Analog level is below the loss threshold |
| los | output | 1 | Loss-of-signal indication |
| los_status | output | 1 | Host-visible copy of the loss flag |
| out_pos | output | 1 | Squelched positive rail / unipolar data |
| out_neg | output | 1 | Squelched negative rail |

## Verification
Every result is registered once. A bit period, or a cycle with an outside cause, that is sampled at one rising edge shows up on `los` and on both data outputs just after that same edge. So the expected values are due one cycle after the stimulus is driven. The bench drives inputs on falling edges. Its reference model advances at each rising edge, and it compares all outputs shortly after every falling edge, half a cycle clear of the edge that updates them. The directed boundary checks (bit 174 versus bit 175 of a zero run, the first bit after a 101-zero run leaves the window) are taken right after the bit period in question has been sampled.

// File: rtl/los_pkg.sv
package los_pkg;

   // One received symbol after rail decoding
   typedef struct packed {
      logic mark;
      logic pos;
      logic neg;
   } los_sym_t;

   // Action chosen by the state controller on a given cycle
   typedef enum logic [1:0] {
      LOS_ACT_HOLD    = 2'd0,
      LOS_ACT_DECLARE = 2'd1,
      LOS_ACT_CLEAR   = 2'd2
   } los_act_e;

   // Counter width able to hold the value n
   function automatic int unsigned los_cnt_w(input int unsigned n);
      return (n < 2) ? 1 : $clog2(n + 1);
   endfunction

endpackage

// File: rtl/los_sym_decode.sv
module los_sym_decode
   import los_pkg::*;
#(
   parameter bit BIPOLAR = 1'b1
) (
   input  logic     clk,
   input  logic     rst_n,
   input  logic     bit_en,
   input  logic     rx_pos,
   input  logic     rx_neg,
   output los_sym_t sym,
   output logic     q_pos,
   output logic     q_neg
);

   generate
      if (BIPOLAR) begin : g_bipolar
         // Either rail carrying a pulse counts as a mark
         always_comb begin
            sym.pos  = rx_pos;
            sym.neg  = rx_neg;
            sym.mark = rx_pos | rx_neg;
         end

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               q_pos <= 1'b0;
               q_neg <= 1'b0;
            end else if (bit_en) begin
               q_pos <= rx_pos;
               q_neg <= rx_neg;
            end
         end
      end else begin : g_unipolar
         // Single data line; second rail has no meaning here
         always_comb begin
            sym.pos  = rx_pos;
            sym.neg  = 1'b0;
            sym.mark = rx_pos;
         end

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               q_pos <= 1'b0;
            end else if (bit_en) begin
               q_pos <= rx_pos;
            end
         end

         assign q_neg = 1'b0;
      end
   endgenerate

endmodule

// File: rtl/los_zero_run.sv
module los_zero_run
   import los_pkg::*;
#(
   parameter int unsigned DECL_ZEROS = 175,
   parameter int unsigned MAX_RUN    = 100,
   parameter int unsigned WIN        = 175
) (
   input  logic clk,
   input  logic rst_n,
   input  logic bit_en,
   input  logic mark,
   output logic decl_hit,
   output logic blocked_nxt
);

   localparam int unsigned ZW   = los_cnt_w(DECL_ZEROS);
   localparam int unsigned HOLD = WIN - MAX_RUN;
   localparam int unsigned BW   = los_cnt_w(HOLD);

   logic [ZW-1:0] zr_q, zr_nxt;
   logic [BW-1:0] blk_q, blk_nxt;
   logic          long_ev;

   // Saturating count of consecutive zeros
   always_comb begin
      if (mark)
         zr_nxt = '0;
      else if (zr_q == ZW'(DECL_ZEROS))
         zr_nxt = zr_q;
      else
         zr_nxt = zr_q + ZW'(1);
   end

   assign decl_hit = bit_en && !mark && (zr_nxt >= ZW'(DECL_ZEROS));

   // A bit that ends a zero run longer than MAX_RUN keeps exit blocked
   // until the earliest zero of that run has left the window.
   assign long_ev = bit_en && (zr_nxt > ZW'(MAX_RUN));

   always_comb begin
      if (long_ev)
         blk_nxt = BW'(HOLD);
      else if (bit_en && (blk_q != '0))
         blk_nxt = blk_q - BW'(1);
      else
         blk_nxt = blk_q;
   end

   assign blocked_nxt = (blk_nxt != '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         zr_q  <= '0;
         blk_q <= '0;
      end else begin
         if (bit_en) zr_q <= zr_nxt;
         blk_q <= blk_nxt;
      end
   end

endmodule

// File: rtl/los_density_window.sv
module los_density_window
   import los_pkg::*;
#(
   parameter int unsigned WIN      = 175,
   parameter int unsigned MIN_ONES = 22
) (
   input  logic clk,
   input  logic rst_n,
   input  logic bit_en,
   input  logic mark,
   input  logic restart,
   output logic dense_nxt,
   output logic full_nxt
);

   localparam int unsigned OW = los_cnt_w(WIN);

   logic [WIN-1:0] hist_q;
   logic [OW-1:0]  ones_q, ones_nxt;
   logic [OW-1:0]  obs_q, obs_inc;
   logic           oldest;

   assign oldest = hist_q[WIN-1];

   // Running total of marks in the window: add the newest, drop the oldest
   always_comb begin
      if (bit_en)
         ones_nxt = ones_q + OW'(mark) - OW'(oldest);
      else
         ones_nxt = ones_q;
   end

   assign dense_nxt = (ones_nxt >= OW'(MIN_ONES));

   // Bit periods seen since the last declaration, saturating at WIN
   always_comb begin
      if (bit_en && (obs_q < OW'(WIN)))
         obs_inc = obs_q + OW'(1);
      else
         obs_inc = obs_q;
   end

   assign full_nxt = (obs_inc >= OW'(WIN));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hist_q <= '0;
         ones_q <= '0;
         obs_q  <= '0;
      end else begin
         if (bit_en) begin
            hist_q <= {hist_q[WIN-2:0], mark};
         end
         ones_q <= ones_nxt;
         obs_q  <= restart ? '0 : obs_inc;
      end
   end

endmodule

// File: rtl/los_ctrl.sv
module los_ctrl
   import los_pkg::*;
#(
   parameter bit HOST_MODE = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic bit_en,
   input  logic gain_max,
   input  logic low_level,
   input  logic decl_hit,
   input  logic full_nxt,
   input  logic dense_nxt,
   input  logic blocked_nxt,
   output logic declare,
   output logic los,
   output logic los_status
);

   los_act_e act;

   assign declare = gain_max || low_level || decl_hit;

   always_comb begin
      if (declare)
         act = LOS_ACT_DECLARE;
      else if (los && bit_en && full_nxt && dense_nxt && !blocked_nxt)
         act = LOS_ACT_CLEAR;
      else
         act = LOS_ACT_HOLD;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         los <= 1'b1;
      end else begin
         case (act)
            LOS_ACT_DECLARE: los <= 1'b1;
            LOS_ACT_CLEAR:   los <= 1'b0;
            default:         los <= los;
         endcase
      end
   end

   generate
      if (HOST_MODE) begin : g_host
         assign los_status = los;
      end else begin : g_pin_only
         assign los_status = 1'b0;
      end
   endgenerate

endmodule

// File: rtl/los_detector.sv
module los_detector
   import los_pkg::*;
#(
   parameter bit          BIPOLAR    = 1'b1,
   parameter bit          HOST_MODE  = 1'b1,
   parameter int unsigned DECL_ZEROS = 175,
   parameter int unsigned WIN        = 175,
   parameter int unsigned MIN_ONES   = 22,
   parameter int unsigned MAX_RUN    = 100
) (
   input  logic clk,
   input  logic rst_n,
   input  logic bit_en,
   input  logic rx_pos,
   input  logic rx_neg,
   input  logic gain_max,
   input  logic low_level,
   output logic los,
   output logic los_status,
   output logic out_pos,
   output logic out_neg
);

   // Elaboration-time parameter checks
   if (WIN < 2) begin : g_bad_win
      $error("los_detector: WIN must be at least 2");
   end
   if ((MIN_ONES == 0) || (MIN_ONES > WIN)) begin : g_bad_ones
      $error("los_detector: MIN_ONES must lie in 1..WIN");
   end
   if (MAX_RUN >= WIN) begin : g_bad_run
      $error("los_detector: MAX_RUN must be below WIN");
   end
   if (DECL_ZEROS <= MAX_RUN) begin : g_bad_decl
      $error("los_detector: DECL_ZEROS must exceed MAX_RUN");
   end

   los_sym_t sym;
   logic     q_pos, q_neg;
   logic     decl_hit, blocked_nxt;
   logic     dense_nxt, full_nxt;
   logic     declare;

   los_sym_decode #(
      .BIPOLAR (BIPOLAR)
   ) u_decode (
      .clk    (clk),
      .rst_n  (rst_n),
      .bit_en (bit_en),
      .rx_pos (rx_pos),
      .rx_neg (rx_neg),
      .sym    (sym),
      .q_pos  (q_pos),
      .q_neg  (q_neg)
   );

   los_zero_run #(
      .DECL_ZEROS (DECL_ZEROS),
      .MAX_RUN    (MAX_RUN),
      .WIN        (WIN)
   ) u_zero_run (
      .clk         (clk),
      .rst_n       (rst_n),
      .bit_en      (bit_en),
      .mark        (sym.mark),
      .decl_hit    (decl_hit),
      .blocked_nxt (blocked_nxt)
   );

   los_density_window #(
      .WIN      (WIN),
      .MIN_ONES (MIN_ONES)
   ) u_window (
      .clk       (clk),
      .rst_n     (rst_n),
      .bit_en    (bit_en),
      .mark      (sym.mark),
      .restart   (declare),
      .dense_nxt (dense_nxt),
      .full_nxt  (full_nxt)
   );

   los_ctrl #(
      .HOST_MODE (HOST_MODE)
   ) u_ctrl (
      .clk         (clk),
      .rst_n       (rst_n),
      .bit_en      (bit_en),
      .gain_max    (gain_max),
      .low_level   (low_level),
      .decl_hit    (decl_hit),
      .full_nxt    (full_nxt),
      .dense_nxt   (dense_nxt),
      .blocked_nxt (blocked_nxt),
      .declare     (declare),
      .los         (los),
      .los_status  (los_status)
   );

   // Squelch received data while loss is declared
   assign out_pos = q_pos & ~los;
   assign out_neg = q_neg & ~los;

endmodule

// File: rtl/los_detector_chk.sv
module los_detector_chk #(
   parameter bit          BIPOLAR    = 1'b1,
   parameter int unsigned DECL_ZEROS = 175
) (
   input logic clk,
   input logic rst_n,
   input logic bit_en,
   input logic rx_pos,
   input logic rx_neg,
   input logic gain_max,
   input logic low_level,
   input logic los,
   input logic out_pos,
   input logic out_neg
);

   logic        mk;
   logic [15:0] zc;

   assign mk = BIPOLAR ? (rx_pos | rx_neg) : rx_pos;

   // Independent count of consecutive zeros seen at the ports
   always_ff @(posedge clk) begin
      if (!rst_n)
         zc <= '0;
      else if (bit_en)
         zc <= mk ? 16'd0 : ((zc == 16'hFFFF) ? zc : zc + 16'd1);
   end

   AST_RESET_LOSS: assert property (@(posedge clk)
      !rst_n |=> los);  // R1

   AST_ZERO_RUN_DECLARE: assert property (@(posedge clk) disable iff (!rst_n)
      (bit_en && !mk && (zc >= 16'(DECL_ZEROS - 1))) |=> los);  // R2

   AST_EXT_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      (gain_max || low_level) |=> los);  // R3

   AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (!bit_en && !gain_max && !low_level) |=> $stable(los));  // R4

   AST_EXIT_ON_BIT: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(los) |-> ($past(bit_en) && !$past(gain_max) && !$past(low_level)));  // R5

   AST_SQUELCH: assert property (@(posedge clk) disable iff (!rst_n)
      los |-> (!out_pos && !out_neg));  // R7

endmodule

bind los_detector los_detector_chk #(
   .BIPOLAR    (BIPOLAR),
   .DECL_ZEROS (DECL_ZEROS)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bit_en    (bit_en),
   .rx_pos    (rx_pos),
   .rx_neg    (rx_neg),
   .gain_max  (gain_max),
   .low_level (low_level),
   .los       (los),
   .out_pos   (out_pos),
   .out_neg   (out_neg)
);

// File: tb/tb_los_detector.sv
module tb_los_detector;

   localparam int WIN  = 175;
   localparam int DZ   = 175;
   localparam int MINO = 22;
   localparam int MAXR = 100;

   logic clk = 1'b0;
   always #4 clk = ~clk;

   logic rst_n = 1'b0;
   logic bit_en = 1'b0, rx_pos = 1'b0, rx_neg = 1'b0;
   logic gain_max = 1'b0, low_level = 1'b0, noise = 1'b0;
   logic los, los_status, out_pos, out_neg;
   logic u_los, u_status, u_pos, u_neg;
   logic u_rx_pos;

   assign u_rx_pos = rx_pos | rx_neg;

   los_detector dut (
      .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .rx_pos(rx_pos), .rx_neg(rx_neg),
      .gain_max(gain_max), .low_level(low_level), .los(los), .los_status(los_status),
      .out_pos(out_pos), .out_neg(out_neg)
   );

   los_detector #(.BIPOLAR(1'b0), .HOST_MODE(1'b0)) dut_uni (
      .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .rx_pos(u_rx_pos), .rx_neg(noise),
      .gain_max(gain_max), .low_level(low_level), .los(u_los), .los_status(u_status),
      .out_pos(u_pos), .out_neg(u_neg)
   );

   int n_chk = 0, n_fail = 0;
   bit done = 1'b0;
   bit pol = 1'b0;

   // ---------------- behavioural reference model ----------------
   bit m_los = 1'b1, m_pos = 1'b0, m_neg = 1'b0, m_upos = 1'b0;
   int m_zr = 0, m_obs = 0;
   bit m_hist[$];
   bit m_decl, m_mk;

   function automatic int ones_in();
      int n = 0;
      foreach (m_hist[i]) n += m_hist[i];
      return n;
   endfunction

   function automatic int longest_zero_run();
      int best = 0, cur = 0;
      foreach (m_hist[i]) begin
         if (m_hist[i]) cur = 0;
         else begin
            cur++;
            if (cur > best) best = cur;
         end
      end
      return best;
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_los = 1'b1; m_pos = 1'b0; m_neg = 1'b0; m_upos = 1'b0;
         m_zr = 0; m_obs = 0;
         m_hist.delete();
      end else begin
         m_mk   = rx_pos | rx_neg;
         m_decl = gain_max || low_level;
         if (bit_en) begin
            m_pos = rx_pos; m_neg = rx_neg; m_upos = m_mk;
            m_zr  = m_mk ? 0 : m_zr + 1;
            m_hist.push_front(m_mk);
            if (m_hist.size() > WIN) void'(m_hist.pop_back());
            if (m_zr >= DZ) m_decl = 1'b1;
         end
         if (m_decl) begin
            m_los = 1'b1;
            m_obs = 0;
         end else if (bit_en) begin
            if (m_obs < WIN) m_obs++;
            if (m_los && (m_obs >= WIN) && (ones_in() >= MINO) && (longest_zero_run() <= MAXR))
               m_los = 1'b0;
         end
      end
   end

   // ---------------- checking ----------------
   task automatic chk(input string req, input string what, input logic act, input logic exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s actual=%b expected=%b at %0t", req, what, act, exp, $time);
      end
   endtask

   // Every cycle, half a clock after the updating edge
   always @(negedge clk) begin
      #1;
      if (!done) begin
         chk("R5", "los vs model", los, m_los);
         chk("R9", "host status", los_status, m_los);
         chk("R7", "out_pos", out_pos, m_pos & ~m_los);
         chk("R7", "out_neg", out_neg, m_neg & ~m_los);
         chk("R8", "unipolar los", u_los, m_los);
         chk("R8", "unipolar out_pos", u_pos, m_upos & ~m_los);
         chk("R8", "unipolar out_neg", u_neg, 1'b0);
         chk("R9", "status without host mode", u_status, 1'b0);
      end
   end

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
   endtask

   // ---------------- stimulus ----------------
   task automatic send(input bit b);
      @(negedge clk);
      bit_en = 1'b1;
      noise  = 1'($urandom);
      if (b) begin
         rx_pos = ~pol; rx_neg = pol; pol = ~pol;
      end else begin
         rx_pos = 1'b0; rx_neg = 1'b0;
      end
      repeat (1 + ($urandom % 2)) begin
         @(negedge clk);
         bit_en = 1'b0;
         rx_pos = 1'($urandom); rx_neg = 1'($urandom); noise = 1'($urandom);
      end
   endtask

   task automatic idle(input int n);
      repeat (n) begin
         @(negedge clk);
         bit_en = 1'b0;
         rx_pos = 1'($urandom); rx_neg = 1'($urandom); noise = 1'($urandom);
      end
   endtask

   // Directed check taken just after the most recent sampled bit
   task automatic look(input string req, input string what, input logic act, input logic exp);
      #2;
      chk(req, what, act, exp);
   endtask

   initial begin
      repeat (4) @(negedge clk);
      look("R1", "los in reset", los, 1'b1);
      look("R1", "out_pos in reset", out_pos, 1'b0);
      @(negedge clk);
      rst_n = 1'b1;

      // R1 / R5: density one in four; exit on the 175th bit after reset
      for (int i = 0; i < 174; i++) send((i % 4) == 0);
      look("R1", "still in loss after 174 bits", los, 1'b1);
      send(1'b0);
      look("R5", "exit at 175th bit", los, 1'b0);

      // R2: 174 zeros do not declare, the 175th does
      send(1'b1);
      for (int i = 0; i < 174; i++) send(1'b0);
      look("R2", "174 zeros", los, 1'b0);
      idle(300);
      look("R4", "idle cycles with noisy rails", los, 1'b0);
      send(1'b0);
      look("R2", "175th zero declares", los, 1'b1);

      // R5: one in nine is below the density threshold
      for (int i = 0; i < 400; i++) send((i % 9) == 0);
      look("R5", "sparse density keeps loss", los, 1'b1);
      // one in eight reaches 22 marks in some window
      for (int i = 0; i < 400; i++) send((i % 8) == 0);
      look("R5", "density one in eight clears", los, 1'b0);

      // R6: a 101-zero run inside the window blocks exit
      for (int i = 0; i < DZ; i++) send(1'b0);
      look("R2", "declared again", los, 1'b1);
      for (int i = 0; i < 60; i++) send((i % 2) == 0);
      for (int i = 0; i < 101; i++) send(1'b0);
      for (int i = 0; i < 70; i++) send(1'b1);
      look("R6", "long run still in window", los, 1'b1);
      look("R7", "squelched rails", out_pos | out_neg, 1'b0);
      for (int i = 0; i < 10; i++) send(1'b1);
      look("R6", "long run left window", los, 1'b0);
      look("R7", "data passes after exit", out_pos | out_neg, 1'b1);

      // R3: outside causes
      @(negedge clk);
      bit_en = 1'b0; gain_max = 1'b1;
      @(negedge clk);
      gain_max = 1'b0;
      look("R3", "gain at maximum", los, 1'b1);
      low_level = 1'b1;
      idle(3);
      low_level = 1'b0;
      for (int i = 0; i < 174; i++) send(1'b1);
      look("R3", "window restarted by low level", los, 1'b1);
      send(1'b1);
      look("R3", "exit 175 bits after cause drops", los, 1'b0);

      idle(5);
      done = 1'b1;
      summary();
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_chk++;
         n_fail++;
         $display("FAIL R4 watchdog actual=running expected=finished");
         summary();
         $finish;
      end
   end

endmodule